// File: doc/BRIEF.md
# Multi-Width Rotate-Right Unit

This unit rotates the low N bits of a 64-bit operand to the right, where N is 8, 16, 32 or 64 and is picked per operation by a two-bit size code. The rotate count comes from one of two sources: the low bits of a register count, or a small immediate field. A select input chooses between them. Only the low log2(N) bits of the chosen count are used. The N-bit rotated value is sign-extended to 64 bits before it leaves the unit. Operand bits above N never reach the result.

The two narrow sizes have a latency of two cycles. The two wide sizes have a latency of one cycle. Results still leave the unit in the order in which the operations were accepted. To keep that order, the unit lowers `in_ready` for a wide operation presented in the cycle after a narrow one was accepted. A new operation can be accepted every cycle unless that case occurs. An operation is accepted on a rising clock edge at which both `in_valid` and `in_ready` are high.

Top module: `rotr_unit`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high, and this holds until an operation is accepted.
- R2: The size code is 0 for N=8, 1 for N=16, 2 for N=32 and 3 for N=64. The effective count is the chosen count source modulo N. The source is `in_cnt_imm` when `in_use_imm` is 1, and `in_cnt_reg` when `in_use_imm` is 0. The source that is not selected has no effect.
- R3: An effective count of zero returns the low N bits of the operand unchanged, before sign extension.
- R4: For a nonzero effective count c, the N-bit result is (v >> c) | (v << (N-c)), truncated to N bits.
- R5: For N of 8, 16 or 32, bits 63 down to N of `out_data` are all copies of result bit N-1. For N of 64, the rotated value is output as it is.
- R6: Operand bits at positions N and above have no effect on `out_data`.
- R7: For size codes 0 and 1, `out_valid` is high with the result two cycles after acceptance. For size codes 2 and 3, it is high one cycle after acceptance. In any other cycle `out_valid` is low.
- R8: `in_ready` is low exactly when a size-2 or size-3 operation is presented in the cycle right after a size-0 or size-1 acceptance. Results come out in acceptance order, and at most one result leaves per cycle.
- R9: Narrow operations presented back to back are each accepted in consecutive cycles without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The presented operation can be accepted this cycle |
| in_data | input | 64 | Operand; its low N bits are rotated |
| in_cnt_reg | input | 6 | Low bits of the register count source |
| in_cnt_imm | input | 6 | Immediate count source |
| in_use_imm | input | 1 | 1 selects the immediate count, 0 selects the register count |
| in_size | input | 2 | Size code: 0=8, 1=16, 2=32, 3=64 bits |
| out_valid | output | 1 | A result is present on `out_data` |
| out_data | output | 64 | Sign-extended rotate result |

## Verification
The two paths that can collide are a two-cycle narrow rotate in its second stage and a one-cycle wide rotate that has just been accepted. Both would write the output register in the same cycle. The bench provokes this by presenting a narrow operation and then, with no gap, a wide one. It also presents narrow-then-narrow and wide-then-narrow pairs. A behavioural model predicts the stall from the size of the previous acceptance, predicts the cycle in which each result is due, and on every clock compares `in_ready`, `out_valid` and `out_data` with that prediction.

// File: rtl/rotr_pkg.sv
package rotr_pkg;

  localparam int XLEN  = 64;
  localparam int CNT_W = $clog2(XLEN);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } rot_size_e;

  // Width in bits of the rotated field for a size code.
  function automatic int field_bits(input rot_size_e sz);
    return 8 << sz;
  endfunction

  // Narrow sizes take the two-cycle path.
  function automatic logic takes_two(input rot_size_e sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF);
  endfunction

  // Reduce a count modulo the field width.
  function automatic logic [CNT_W-1:0] wrap_count(input logic [CNT_W-1:0] cnt,
                                                  input rot_size_e sz);
    logic [CNT_W-1:0] lim;
    lim = CNT_W'(field_bits(sz) - 1);
    return cnt & lim;
  endfunction

  // Copy the top bit of the field into every higher position.
  function automatic logic [XLEN-1:0] widen_signed(input logic [XLEN-1:0] val,
                                                   input rot_size_e sz);
    logic [XLEN-1:0] res;
    int n;
    n = field_bits(sz);
    for (int i = 0; i < XLEN; i++) begin
      res[i] = (i < n) ? val[i] : val[n-1];
    end
    return res;
  endfunction

  // Fill the whole word with copies of the low field, so that a
  // full-width rotate wraps at the field boundary.
  function automatic logic [XLEN-1:0] tile_field(input logic [XLEN-1:0] val,
                                                 input rot_size_e sz);
    logic [XLEN-1:0] res;
    int n;
    n = field_bits(sz);
    for (int i = 0; i < XLEN; i++) begin
      res[i] = val[i & (n - 1)];
    end
    return res;
  endfunction

endpackage

// File: rtl/rotr_count.sv
module rotr_count
  import rotr_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [CW-1:0] cnt_reg,
  input  logic [CW-1:0] cnt_imm,
  input  logic          use_imm,
  input  rot_size_e     size,
  output logic [CW-1:0] eff_cnt
);

  logic [CW-1:0] src_cnt;

  always_comb begin
    src_cnt = use_imm ? cnt_imm : cnt_reg;
    eff_cnt = CW'(wrap_count(CNT_W'(src_cnt), size));
  end

endmodule

// File: rtl/rotr_barrel.sv
module rotr_barrel
  import rotr_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  rot_size_e     size,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  rot
);

  logic [CW:0][W-1:0] stage;

  assign stage[0] = tile_field(val, size);

  for (genvar k = 0; k < CW; k++) begin : g_step
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]}
                               : stage[k];
  end

  assign rot = stage[CW];

endmodule

// File: rtl/rotr_sext.sv
module rotr_sext
  import rotr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] val,
  input  rot_size_e    size,
  output logic [W-1:0] res
);

  always_comb begin
    res = widen_signed(val, size);
  end

endmodule

// File: rtl/rotr_unit.sv
module rotr_unit
  import rotr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_data,
  input  logic [CNT_W-1:0] in_cnt_reg,
  input  logic [CNT_W-1:0] in_cnt_imm,
  input  logic             in_use_imm,
  input  logic [1:0]       in_size,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_data
);

  rot_size_e        size_in;
  logic [CNT_W-1:0] eff_cnt;
  logic [XLEN-1:0]  rot_raw;

  logic             mid_valid;
  logic [XLEN-1:0]  mid_data;
  rot_size_e        mid_size;

  logic             slow_op;
  logic             fast_accept;
  logic             slow_accept;
  logic             out_from_mid;
  logic [XLEN-1:0]  sel_val;
  rot_size_e        sel_size;
  logic [XLEN-1:0]  sext_out;

  assign size_in = rot_size_e'(in_size);
  assign slow_op = takes_two(size_in);

  rotr_count #(.CW(CNT_W)) u_count (
    .cnt_reg (in_cnt_reg),
    .cnt_imm (in_cnt_imm),
    .use_imm (in_use_imm),
    .size    (size_in),
    .eff_cnt (eff_cnt)
  );

  rotr_barrel #(.W(XLEN), .CW(CNT_W)) u_barrel (
    .val  (in_data),
    .size (size_in),
    .amt  (eff_cnt),
    .rot  (rot_raw)
  );

  // A wide op may not land on the same output cycle as a narrow op in stage two.
  assign in_ready     = !(mid_valid && !slow_op);
  assign fast_accept  = in_valid && in_ready && !slow_op;
  assign slow_accept  = in_valid && in_ready && slow_op;
  assign out_from_mid = mid_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_valid <= 1'b0;
      mid_data  <= '0;
      mid_size  <= SZ_BYTE;
    end else begin
      mid_valid <= slow_accept;
      if (slow_accept) begin
        mid_data <= rot_raw;
        mid_size <= size_in;
      end
    end
  end

  always_comb begin
    sel_val  = out_from_mid ? mid_data : rot_raw;
    sel_size = out_from_mid ? mid_size : size_in;
  end

  rotr_sext #(.W(XLEN)) u_sext (
    .val  (sel_val),
    .size (sel_size),
    .res  (sext_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= out_from_mid || fast_accept;
      if (out_from_mid || fast_accept) begin
        out_data <= sext_out;
      end
    end
  end

  // R2: the reduced count never reaches the field width
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(eff_cnt) < field_bits(size_in)));

  // R3: a zero count leaves the field as it was
  p_zero_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_accept && eff_cnt == '0) |=>
      (out_data == widen_signed($past(in_data), rot_size_e'($past(in_size)))));

  // R5: bits above a byte field copy its top bit
  p_sext_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_size == SZ_BYTE) |-> ((sext_out[XLEN-1:7] == '0) || (&sext_out[XLEN-1:7])));

  // R7: wide ops appear one cycle after acceptance
  p_fast_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_accept |=> out_valid);

  // R7: narrow ops appear two cycles after acceptance
  p_slow_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    slow_accept |=> ##1 out_valid);

  // R8: stage two and a wide op never compete for the output
  p_no_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_from_mid && fast_accept));

endmodule

// File: tb/rotr_unit_bench.sv
module rotr_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [5:0]  in_cnt_reg = '0;
  logic [5:0]  in_cnt_imm = '0;
  logic        in_use_imm = 1'b0;
  logic [1:0]  in_size = '0;
  logic        out_valid;
  logic [63:0] out_data;

  typedef struct {
    logic [63:0] val;
    int          due;
    string       tag;
  } exp_t;

  exp_t  expq[$];
  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    slow_prev = 0;
  string cur_tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  rotr_unit u_rotr_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_cnt_reg (in_cnt_reg),
    .in_cnt_imm (in_cnt_imm),
    .in_use_imm (in_use_imm),
    .in_size    (in_size),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  // Behavioural reference: bit i of the result takes bit (i+c) mod n.
  function automatic logic [63:0] model(input logic [63:0] d, input int cnt, input int sz);
    int n;
    int c;
    logic [63:0] r;
    n = 8 * (1 << sz);
    c = cnt % n;
    r = '0;
    for (int i = 0; i < n; i++) r[i] = d[(i + c) % n];
    for (int i = n; i < 64; i++) r[i] = r[n-1];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_v;
      bit acc;
      bit slow_now;
      cyc++;
      exp_v = (expq.size() > 0) && (expq[0].due == cyc);
      check(out_valid == exp_v, "R7", 64'(out_valid), 64'(exp_v));
      if (exp_v) begin
        check(out_data == expq[0].val, expq[0].tag, out_data, expq[0].val);
        void'(expq.pop_front());
      end
      slow_now = (in_size < 2);
      if (in_valid) begin
        bit exp_rdy;
        exp_rdy = !(slow_prev && !slow_now);
        check(in_ready == exp_rdy, "R8", 64'(in_ready), 64'(exp_rdy));
      end
      acc = in_valid && in_ready;
      if (acc) begin
        exp_t e;
        e.val = model(in_data, in_use_imm ? int'(in_cnt_imm) : int'(in_cnt_reg), int'(in_size));
        e.due = cyc + (slow_now ? 2 : 1);
        e.tag = cur_tag;
        expq.push_back(e);
      end
      slow_prev = acc && slow_now;
      if (cyc > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic issue(input logic [63:0] d, input logic [5:0] creg, input logic [5:0] cimm,
                       input bit ui, input logic [1:0] sz, input string tag);
    in_data    = d;
    in_cnt_reg = creg;
    in_cnt_imm = cimm;
    in_use_imm = ui;
    in_size    = sz;
    cur_tag    = tag;
    in_valid   = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state before anything is accepted
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    check(out_data == '0, "R1", out_data, 64'd0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);

    // R4: one op of every size, spaced out
    issue(64'h0000_0000_0000_0081, 6'd1,  6'd0,  1'b0, 2'd0, "R4");
    idle(3);
    issue(64'h0000_0000_0000_1234, 6'd4,  6'd0,  1'b0, 2'd1, "R4");
    idle(3);
    issue(64'h0000_0000_89AB_CDEF, 6'd12, 6'd0,  1'b0, 2'd2, "R4");
    idle(3);
    issue(64'h0123_4567_89AB_CDEF, 6'd36, 6'd0,  1'b0, 2'd3, "R4");
    idle(3);

    // R2: immediate vs register source, modulo reduction
    issue(64'h0000_0000_0000_00C3, 6'd5,  6'd2,  1'b1, 2'd0, "R2");
    issue(64'h0000_0000_0000_00C3, 6'd13, 6'd40, 1'b0, 2'd0, "R2");
    issue(64'h0000_0000_0000_8001, 6'd0,  6'd33, 1'b1, 2'd1, "R2");
    issue(64'h0000_0000_F000_000F, 6'd63, 6'd7,  1'b0, 2'd2, "R2");
    idle(3);

    // R3: effective count zero, including a count equal to the width
    issue(64'h0000_0000_0000_8421, 6'd16, 6'd0,  1'b0, 2'd1, "R3");
    issue(64'hFEDC_BA98_7654_3210, 6'd0,  6'd0,  1'b1, 2'd3, "R3");
    issue(64'h0000_0000_0000_007F, 6'd8,  6'd0,  1'b0, 2'd0, "R3");
    idle(3);

    // R5: sign extension of negative and positive results
    issue(64'h0000_0000_0000_0001, 6'd1,  6'd0,  1'b0, 2'd2, "R5");
    issue(64'h0000_0000_0000_0002, 6'd1,  6'd0,  1'b0, 2'd2, "R5");
    issue(64'h0000_0000_0000_0001, 6'd1,  6'd0,  1'b0, 2'd3, "R5");
    issue(64'h0000_0000_0000_0100, 6'd9,  6'd0,  1'b0, 2'd1, "R5");
    idle(3);

    // R6: garbage above the field
    issue(64'hFFFF_FFFF_FFFF_FF12, 6'd3,  6'd0,  1'b0, 2'd0, "R6");
    issue(64'h5A5A_5A5A_5A5A_0012, 6'd3,  6'd0,  1'b0, 2'd0, "R6");
    issue(64'hDEAD_BEEF_0000_7001, 6'd2,  6'd0,  1'b0, 2'd2, "R6");
    idle(3);

    // R8: narrow then wide, stall expected; order preserved
    issue(64'h0000_0000_0000_00A5, 6'd3,  6'd0,  1'b0, 2'd0, "R8");
    issue(64'h0000_0000_1357_9BDF, 6'd8,  6'd0,  1'b0, 2'd2, "R8");
    issue(64'h0000_0000_0000_F00D, 6'd5,  6'd0,  1'b0, 2'd1, "R8");
    issue(64'h1111_2222_3333_4444, 6'd17, 6'd0,  1'b0, 2'd3, "R8");
    idle(3);

    // R9: narrow ops back to back, then wide then narrow
    issue(64'h0000_0000_0000_0011, 6'd1,  6'd0,  1'b0, 2'd0, "R9");
    issue(64'h0000_0000_0000_2233, 6'd2,  6'd0,  1'b0, 2'd1, "R9");
    issue(64'h0000_0000_0000_0044, 6'd3,  6'd0,  1'b0, 2'd0, "R9");
    issue(64'h0000_0000_5566_7788, 6'd4,  6'd0,  1'b0, 2'd2, "R9");
    issue(64'h0000_0000_0000_0099, 6'd5,  6'd0,  1'b0, 2'd0, "R9");
    idle(4);

    // R7: nothing left outstanding
    check(expq.size() == 0, "R7", 64'(expq.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule